// File: doc/BRIEF.md
# Throttled SPI Transmit DMA Channel

This channel copies a memory buffer into the transmit data register of an SPI controller, one burst per scheduler slot. On each `start` it first reads the controller's status word and looks at how many entries sit in the transmit FIFO. If the FIFO is too full, it gives the slot back at once. Otherwise it moves one burst of bytes. The words written are 8, 16, 24 or 32 bits wide. After the burst it can set the exchange-start bit in the controller's control register.

A descriptor gives the buffer address, a command word (byte count and width select) and a burst length word, and is loaded while the channel is idle. The remaining count and the memory pointer stay in registers between slots. A burst that was skipped, or one that follows a finished burst, therefore picks up where the last one stopped. Any bus error ends the buffer and raises a failure pulse.

Top module: `spi_tx_dma`

## Requirements
- R1: On `start` with bytes left, the channel reads the peripheral at base + 0x1C and takes the FIFO level from bits 15:8. A level of 48 or more gives a `burst_done` pulse with no memory traffic and no write.
- R2: A burst moves min(burst length with bit 31 cleared, bytes remaining) bytes. That amount is subtracted from the remaining count before any data moves.
- R3: The width comes from command bits 25:24: 00 gives 32-bit, 10 gives 16-bit, 01 gives 8-bit, 11 gives 24-bit.
- R4: In 8/16/32-bit modes the channel performs floor(burst bytes / item size) writes to base + 0. Each is a memory read zero-extended to 32 bits, and the address advances by the item size. `mem_size` is 0 for a byte, 1 for a halfword, 2 for a word, and reads are little-endian.
- R5: In 24-bit mode each write is {8'h00, byte, halfword}, built from one byte read and one halfword read. If the remaining count after the subtraction is even, the byte is read first; if it is odd, the halfword is read first. One word is written per 3 bytes, and a remainder of fewer than 3 bytes is dropped.
- R6: After a burst with burst-length bit 31 clear, base + 4 is read and written back with bit 2 set. With bit 31 set, this step is skipped.
- R7: Any `start` with zero bytes left, including after a zero-count descriptor, pulses `next_desc_req` only. A burst that empties the buffer pulses `burst_done` and `next_desc_req` in the same cycle.
- R8: An error on any memory or peripheral access pulses `fail`, not `burst_done`, and clears the remaining count, so the next `start` only requests a new descriptor.
- R9: Each port holds its request, address, size and write data stable until acknowledged. The two ports are never requested together, and all requests and pulses are low after reset.
- R10: A skipped burst leaves the address and count unchanged, so the following burst reads from the same place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| desc_load | input | 1 | Load descriptor (idle only) |
| desc_addr | input | 32 | Buffer start address |
| desc_cmd | input | 32 | Byte count [15:0], width select [25:24] |
| desc_burst | input | 32 | Burst length [30:0], skip-exchange flag [31] |
| periph_base | input | 32 | SPI controller base address |
| start | input | 1 | Scheduler grant for one burst attempt |
| burst_done | output | 1 | Burst finished or skipped (pulse) |
| next_desc_req | output | 1 | Buffer empty, new descriptor wanted (pulse) |
| fail | output | 1 | Bus error abort (pulse) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_ack | input | 1 | Memory acknowledge with data |
| mem_rdata | input | 32 | Memory read data |
| mem_err | input | 1 | Memory error, valid with ack |
| per_req | output | 1 | Peripheral access request |
| per_we | output | 1 | Peripheral write enable |
| per_addr | output | 32 | Peripheral address |
| per_wdata | output | 32 | Peripheral write data |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rdata | input | 32 | Peripheral read data |
| per_err | input | 1 | Peripheral error, valid with ack |

## Verification
The burst that drains the buffer signals its own completion and the request for a new descriptor in the same cycle. The bench provokes this with descriptors whose count is a whole number of bursts (32-bit and 24-bit), and with a 16-bit case whose final burst is short. It counts a pass only when `burst_done` and `next_desc_req` are seen high in one sampled cycle. Elsewhere it checks that a mid-buffer burst raises `burst_done` alone and that a zero-count start raises `next_desc_req` alone.

// File: rtl/spi_tx_dma.sv
module spi_tx_dma #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int LVL_LSB = 8,
  parameter int LVL_W = 8,
  parameter int FIFO_LIMIT = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_load,
  input  logic [AW-1:0] desc_addr,
  input  logic [31:0]   desc_cmd,
  input  logic [31:0]   desc_burst,
  input  logic [AW-1:0] periph_base,
  input  logic          start,
  output logic          burst_done,
  output logic          next_desc_req,
  output logic          fail,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          per_req,
  output logic          per_we,
  output logic [AW-1:0] per_addr,
  output logic [31:0]   per_wdata,
  input  logic          per_ack,
  input  logic [31:0]   per_rdata,
  input  logic          per_err
);
  typedef enum logic [2:0] {S_IDLE, S_STAT, S_RD_A, S_RD_B, S_WR, S_CTL_RD, S_CTL_WR} st_t;
  st_t st;
  logic [AW-1:0] base, addr;
  logic [CW-1:0] remain, left;
  logic [1:0]    mode;
  logic [31:0]   blen, hold, item;
  logic          odd, done_q, nreq_q, fail_q;

  wire is24 = (mode == 2'b11);
  wire [CW-1:0] unit = (mode == 2'b00) ? CW'(4) : (mode == 2'b10) ? CW'(2) :
                       (mode == 2'b01) ? CW'(1) : CW'(3);
  wire [CW-1:0] take = (31'(remain) < blen[30:0]) ? remain : blen[CW-1:0];
  wire [CW-1:0] rem_after = remain - take;
  wire [CW-1:0] left_next = left - unit;
  wire [LVL_W-1:0] lvl = per_rdata[LVL_LSB +: LVL_W];
  wire over = lvl >= LVL_W'(FIFO_LIMIT);
  wire err = (mem_req & mem_ack & mem_err) | (per_req & per_ack & per_err);
  wire unused_bits = ^{desc_cmd[31:26], desc_cmd[23:CW]};

  assign mem_req  = (st == S_RD_A) || (st == S_RD_B);
  assign mem_addr = addr;
  assign mem_size = is24 ? (((st == S_RD_A) == odd) ? 2'd1 : 2'd0)
                  : (mode == 2'b01) ? 2'd0 : (mode == 2'b10) ? 2'd1 : 2'd2;
  assign per_req  = (st == S_STAT) || (st == S_WR) || (st == S_CTL_RD) || (st == S_CTL_WR);
  assign per_we   = (st == S_WR) || (st == S_CTL_WR);
  assign per_addr = (st == S_STAT) ? base + AW'(32'h1C)
                  : (st == S_CTL_RD || st == S_CTL_WR) ? base + AW'(4) : base;
  assign per_wdata = hold;
  assign burst_done = done_q;
  assign next_desc_req = nreq_q;
  assign fail = fail_q;

  always_comb begin
    case (mode)
      2'b01:   item = {24'h0, mem_rdata[7:0]};
      2'b10:   item = {16'h0, mem_rdata[15:0]};
      default: item = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; addr <= '0; remain <= '0; left <= '0;
      mode <= '0; blen <= '0; hold <= '0; odd <= 1'b0;
      done_q <= 1'b0; nreq_q <= 1'b0; fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0; nreq_q <= 1'b0; fail_q <= 1'b0;
      if (err) begin
        st <= S_IDLE; remain <= '0; fail_q <= 1'b1;
      end else begin
        case (st)
          S_IDLE:
            if (desc_load) begin
              base <= periph_base; addr <= desc_addr; remain <= desc_cmd[CW-1:0];
              mode <= {desc_cmd[25], desc_cmd[24]}; blen <= desc_burst;
            end else if (start) begin
              if (remain == '0) nreq_q <= 1'b1;
              else st <= S_STAT;
            end
          S_STAT:
            if (per_ack) begin
              if (over) begin
                done_q <= 1'b1; st <= S_IDLE;
              end else begin
                remain <= rem_after; left <= take; odd <= rem_after[0];
                if (take >= unit) st <= S_RD_A;
                else if (!blen[31]) st <= S_CTL_RD;
                else begin
                  done_q <= 1'b1; nreq_q <= (rem_after == '0); st <= S_IDLE;
                end
              end
            end
          S_RD_A:
            if (mem_ack) begin
              addr <= addr + (AW'(1) << mem_size);
              if (is24) begin
                hold <= odd ? {16'h0, mem_rdata[15:0]} : {8'h0, mem_rdata[7:0], 16'h0};
                st <= S_RD_B;
              end else begin
                hold <= item; st <= S_WR;
              end
            end
          S_RD_B:
            if (mem_ack) begin
              addr <= addr + (AW'(1) << mem_size);
              if (odd) hold[23:16] <= mem_rdata[7:0];
              else hold[15:0] <= mem_rdata[15:0];
              st <= S_WR;
            end
          S_WR:
            if (per_ack) begin
              left <= left_next;
              if (left_next >= unit) st <= S_RD_A;
              else if (!blen[31]) st <= S_CTL_RD;
              else begin
                done_q <= 1'b1; nreq_q <= (remain == '0); st <= S_IDLE;
              end
            end
          S_CTL_RD:
            if (per_ack) begin
              hold <= per_rdata | 32'h4; st <= S_CTL_WR;
            end
          S_CTL_WR:
            if (per_ack) begin
              done_q <= 1'b1; nreq_q <= (remain == '0); st <= S_IDLE;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module spi_tx_dma_chk #(parameter int AW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic          per_req,
  input logic          per_ack,
  input logic          per_we,
  input logic [AW-1:0] per_addr,
  input logic [31:0]   per_wdata,
  input logic          burst_done,
  input logic          fail
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size)); // R9
  AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && !per_ack |=> per_req && $stable(per_addr) && $stable(per_we) && $stable(per_wdata)); // R9
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n) !(mem_req && per_req)); // R9
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_size != 2'd3); // R4
  AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (!rst_n) !(burst_done && fail)); // R8
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) fail |-> !mem_req && !per_req); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) burst_done |-> !mem_req && !per_req); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) burst_done |=> !burst_done); // R7
endmodule

bind spi_tx_dma spi_tx_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_size(mem_size), .per_req(per_req), .per_ack(per_ack), .per_we(per_we),
  .per_addr(per_addr), .per_wdata(per_wdata), .burst_done(burst_done), .fail(fail)
);

// File: tb/spi_tx_dma_tb.sv
module spi_tx_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h4001_0000;
  localparam logic [31:0] CTL_INIT = 32'h0000_00F1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        desc_load = 0, start = 0;
  logic [31:0] desc_addr = 0, desc_cmd = 0, desc_burst = 0;
  logic        burst_done, next_desc_req, fail;
  logic        mem_req, mem_ack = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [1:0]  mem_size;
  logic        per_req, per_we, per_ack = 0, per_err = 0;
  logic [31:0] per_addr, per_wdata, per_rdata = 0;

  spi_tx_dma u_dut (
    .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_addr(desc_addr),
    .desc_cmd(desc_cmd), .desc_burst(desc_burst), .periph_base(BASE), .start(start),
    .burst_done(burst_done), .next_desc_req(next_desc_req), .fail(fail),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err), .per_req(per_req), .per_we(per_we),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_ack(per_ack),
    .per_rdata(per_rdata), .per_err(per_err)
  );

  int n_cmp = 0, n_bad = 0, mon_cmp = 0, mon_bad = 0;
  int cnt_done = 0, cnt_next = 0, cnt_fail = 0, cnt_both = 0;
  logic [64:0] expq[$];
  string tag = "reset";
  logic inj_mem = 0, inj_per = 0;
  logic [7:0] fifo_lvl = 0;
  logic [31:0] m_addr, m_burst;
  logic [1:0] m_mode;
  int m_rem;

  function automatic logic [7:0] bm(input logic [31:0] a);
    return (a[7:0] * 8'd7) + a[15:8] + 8'h3C;
  endfunction
  function automatic logic [31:0] memword(input logic [31:0] a);
    return {bm(a + 32'd3), bm(a + 32'd2), bm(a + 32'd1), bm(a)};
  endfunction

  // responder and monitor
  always @(negedge clk) begin
    logic [64:0] act, exp;
    mem_ack = mem_req;
    mem_err = mem_req && inj_mem;
    mem_rdata = memword(mem_addr);
    per_ack = per_req;
    per_err = per_req && inj_per;
    per_rdata = (per_addr == BASE + 32'h1C) ? {16'h0, fifo_lvl, 8'h0} : CTL_INIT;
    if (per_req) begin
      act = {per_we, per_addr, per_we ? per_wdata : 32'h0};
      mon_cmp++;
      if (expq.size() == 0) begin
        mon_bad++;
        $display("FAIL %s: unexpected access actual %h expected none", tag, act);
      end else begin
        exp = expq.pop_front();
        if (act !== exp) begin
          mon_bad++;
          $display("FAIL %s: access actual %h expected %h", tag, act, exp);
        end
      end
    end
    if (burst_done) cnt_done++;
    if (next_desc_req) cnt_next++;
    if (fail) cnt_fail++;
    if (burst_done && next_desc_req) cnt_both++;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] cmd, input logic [31:0] bl);
    @(negedge clk);
    desc_addr = a; desc_cmd = cmd; desc_burst = bl; desc_load = 1;
    @(negedge clk);
    desc_load = 0;
    m_addr = a; m_rem = int'(cmd[15:0]); m_mode = cmd[25:24]; m_burst = bl;
  endtask

  task automatic model_xfer();
    int unit, take, n;
    bit odd;
    logic [31:0] w;
    logic [7:0] bt;
    logic [15:0] hw;
    unit = (m_mode == 2'b00) ? 4 : (m_mode == 2'b10) ? 2 : (m_mode == 2'b01) ? 1 : 3;
    take = (int'(m_burst[30:0]) < m_rem) ? int'(m_burst[30:0]) : m_rem;
    m_rem -= take;
    odd = (m_rem % 2) == 1;
    n = take / unit;
    for (int i = 0; i < n; i++) begin
      if (unit == 3) begin
        if (odd) begin hw = {bm(m_addr + 1), bm(m_addr)}; bt = bm(m_addr + 2); end
        else begin bt = bm(m_addr); hw = {bm(m_addr + 2), bm(m_addr + 1)}; end
        w = {8'h0, bt, hw};
      end else if (unit == 1) w = {24'h0, bm(m_addr)};
      else if (unit == 2) w = {16'h0, bm(m_addr + 1), bm(m_addr)};
      else w = memword(m_addr);
      m_addr += unit;
      expq.push_back({1'b1, BASE, w});
    end
    if (!m_burst[31]) begin
      expq.push_back({1'b0, BASE + 32'd4, 32'h0});
      expq.push_back({1'b1, BASE + 32'd4, CTL_INIT | 32'h4});
    end
  endtask

  task automatic run(input string r, input logic [7:0] lvl, input int fault);
    int d0, x0, f0, b0;
    bit ed, en, ef;
    d0 = cnt_done; x0 = cnt_next; f0 = cnt_fail; b0 = cnt_both;
    ed = 0; en = 0; ef = 0;
    tag = r; fifo_lvl = lvl;
    if (m_rem == 0) en = 1;
    else begin
      expq.push_back({1'b0, BASE + 32'h1C, 32'h0});
      if (fault == 2) begin ef = 1; inj_per = 1; m_rem = 0; end
      else if (lvl >= 8'd48) ed = 1;
      else if (fault == 1) begin ef = 1; inj_mem = 1; m_rem = 0; end
      else begin model_xfer(); ed = 1; en = (m_rem == 0); end
    end
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < 300 && cnt_done == d0 && cnt_next == x0 && cnt_fail == f0; i++)
      @(negedge clk);
    repeat (3) @(negedge clk);
    inj_mem = 0; inj_per = 0;
    chk({r, " burst_done"}, cnt_done - d0, ed);
    chk({r, " next_desc_req"}, cnt_next - x0, en);
    chk({r, " fail"}, cnt_fail - f0, ef);
    if (ed && en) chk({r, " done+next same cycle R7"}, cnt_both - b0, 1);
    chk({r, " pending accesses"}, expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset idle", {27'h0, mem_req, per_req, burst_done, fail, next_desc_req}, 0);
    rst_n = 1;
    // 32-bit, two bursts, exchange start each time
    load(32'h100, 32'h0000_0010, 32'd8);
    run("R2 R4 R6 32-bit", 8'd0, 0);
    run("R7 last 32-bit", 8'd0, 0);
    // 8-bit: skip on full FIFO then resume
    load(32'h200, 32'h0100_0003, 32'd4);
    run("R1 skip at 48", 8'd48, 0);
    run("R3 R4 R10 8-bit resume at 47", 8'd47, 0);
    // 16-bit with exchange-start suppressed, short final burst
    load(32'h301, 32'h0200_0007, 32'h8000_0004);
    run("R3 R6 16-bit no exchange", 8'd10, 0);
    run("R4 16-bit floor", 8'd0, 0);
    // 24-bit packing, both parities
    load(32'h400, 32'h0300_0006, 32'd6);
    run("R5 24-bit even byte first", 8'd0, 0);
    load(32'h500, 32'h0300_0007, 32'd6);
    run("R5 24-bit odd halfword first", 8'd0, 0);
    run("R5 24-bit short remainder", 8'd0, 0);
    // zero count
    load(32'h600, 32'h0000_0000, 32'd8);
    run("R7 zero count", 8'd0, 0);
    // faults
    load(32'h700, 32'h0000_0008, 32'd8);
    run("R8 memory error", 8'd0, 1);
    run("R8 after abort", 8'd0, 0);
    load(32'h800, 32'h0000_0008, 32'd8);
    run("R8 peripheral error", 8'd0, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + mon_cmp, n_bad + mon_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + mon_cmp + 1, n_bad + mon_bad + 1);
    $finish;
  end
endmodule